// File: doc/BRIEF.md
# Buffered Block Write Sequencer

This unit runs the multi-word buffered programming sequence of a parallel flash array. A host first writes the buffer-write opcode and then a word count. It then streams count+1 data words. Before it accepts the first data word, the unit copies the whole aligned write block out of storage into a private shadow RAM. Each data word then patches the shadow copy. After the last data word a confirm write decides the outcome. With a clean status, the shadow RAM is streamed back into storage. In any other case the shadow copy is thrown away and the unit goes back to idle.

Storage sits behind a simple word-wide port with a one-cycle read latency. Both copy directions move one word per clock. While a copy is running the ready flag is low, and the host waits for it before the next write. A sticky programming-error flag records every rejected data word. Once it is set, the unit will not commit. The error is cleared only by reset.

Top module: `block_write_unit`

## Requirements
- R1: After reset, sts_ready is 1, sts_prog_err is 0 and seq_idle is 1. Reset also forgets any captured block, so a partly filled shadow copy is never committed.
- R2: In idle, a write whose low data byte is 0xE8 starts the sequence (seq_idle falls) and keeps ready at 1. Any other low byte in idle leaves seq_idle at 1.
- R3: The next write after 0xE8 carries the count. Only its low 8·DEV_BYTES bits are kept, or 8·BANK_BYTES bits when DEV_BYTES is 0. Each data write decrements the count. The write that arrives with the count at zero is the last one, so exactly count+1 data words are taken before the confirm cycle.
- R4: A data write that arrives while no block is captured and with a nonzero count captures a block. The block base is the storage word address with its low log2(block words) bits cleared. All block words are read into the shadow RAM, one per cycle, and sts_ready is 0 from the cycle after that write until the copy and the write itself are done.
- R5: Once a block is captured, a data word whose storage word address lies in a different block sets sts_prog_err and is not stored. The flag stays set until reset.
- R6: A data write made while wr_protect is 1, or while no block is captured (count zero on the first data word), sets sts_prog_err and stores nothing.
- R7: A confirm write with low byte 0xD0 and sts_prog_err at 0 writes every shadow word back into its block in storage. sts_ready is 0 during this copy, and the unit then returns to idle.
- R8: A confirm write with any other low byte, or with sts_prog_err set, leaves storage unchanged and returns to idle at once.
- R9: Byte addresses select storage words by dropping log2(BANK_BYTES) low bits.
- R10: The write block is 256 bytes (BANK_BYTES = 1) or 2048 bytes (wider banks), times BANK_BYTES/DEV_BYTES devices (1 when DEV_BYTES is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Host byte address |
| wr_data | input | 8·BANK_BYTES | Host write data: opcode, count or data word |
| wr_protect | input | 1 | Storage is read-only; data writes are rejected |
| st_re | output | 1 | Storage read request |
| st_we | output | 1 | Storage write request |
| st_addr | output | ADDR_W−log2(BANK_BYTES) | Storage word address |
| st_wdata | output | 8·BANK_BYTES | Storage write data |
| st_rdata | input | 8·BANK_BYTES | Storage read data, valid one cycle after st_re |
| sts_ready | output | 1 | Status ready, low while a copy runs |
| sts_prog_err | output | 1 | Sticky programming error |
| seq_idle | output | 1 | No buffered write sequence is open |

## Verification
The bench builds the unit with BANK_BYTES = 2, DEV_BYTES = 1 and ADDR_W = 13. That gives 2048-word blocks, two blocks of storage and an 8-bit count field. A 16-bit count of 0x0105 therefore has to be cut down to 5. The data table touches the first and the last word of the upper block, which pins the block size and the alignment. Placing the first word of a sequence in one block and a later word in the other exposes the window check. A reset during an open sequence, followed by a fresh commit, shows that the abandoned shadow copy never reaches storage.

// File: rtl/bwu_pkg.sv
package bwu_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_COUNT,
    PH_LOAD,
    PH_FILL,
    PH_PEND,
    PH_CONFIRM,
    PH_FLUSH
  } bwu_phase_e;

  localparam logic [7:0] OP_BUF_WRITE = 8'hE8;
  localparam logic [7:0] OP_CONFIRM   = 8'hD0;

  function automatic int blk_bytes(input int bank, input int dev);
    int ndev;
    ndev = (dev == 0) ? 1 : bank / dev;
    return ((bank == 1) ? 256 : 2048) * ndev;
  endfunction

endpackage

// File: rtl/bwu_ram.sv
module bwu_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/bwu_mover.sv
module bwu_mover #(
  parameter int N  = 1024,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          run,
  output logic [IW-1:0] idx,
  output logic          lag_v,
  output logic [IW-1:0] lag_idx,
  output logic          done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      idx     <= '0;
      lag_v   <= 1'b0;
      lag_idx <= '0;
    end else begin
      lag_v   <= run;
      lag_idx <= idx;
      if (start) begin
        run <= 1'b1;
        idx <= '0;
      end else if (run) begin
        if (idx == IW'(N - 1)) run <= 1'b0;
        else                   idx <= idx + 1'b1;
      end
    end
  end

  assign done = lag_v && (lag_idx == IW'(N - 1));

  AST_MOVER_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && !start && idx != IW'(N - 1)) |=> (idx == $past(idx) + 1'b1)); // R4

endmodule

// File: rtl/block_write_unit.sv
module block_write_unit
  import bwu_pkg::*;
#(
  parameter int BANK_BYTES = 2,
  parameter int DEV_BYTES  = 0,
  parameter int ADDR_W     = 16,
  localparam int DW        = 8 * BANK_BYTES,
  localparam int BOFF      = $clog2(BANK_BYTES),
  localparam int SW        = ADDR_W - BOFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              wr_protect,
  output logic              st_re,
  output logic              st_we,
  output logic [SW-1:0]     st_addr,
  output logic [DW-1:0]     st_wdata,
  input  logic [DW-1:0]     st_rdata,
  output logic              sts_ready,
  output logic              sts_prog_err,
  output logic              seq_idle
);

  localparam int CNT_W = 8 * ((DEV_BYTES == 0) ? BANK_BYTES : DEV_BYTES);
  localparam int WORDS = blk_bytes(BANK_BYTES, DEV_BYTES) / BANK_BYTES;
  localparam int IDX_W = $clog2(WORDS);
  localparam int TAG_W = SW - IDX_W;

  bwu_phase_e       phase;
  logic [CNT_W-1:0] cnt;
  logic             captured;
  logic [TAG_W-1:0] tag;
  logic             err;
  logic [IDX_W-1:0] pend_idx;
  logic [DW-1:0]    pend_data;
  logic             pend_ok;

  logic [SW-1:0]    w_word;
  logic [TAG_W-1:0] w_tag;
  logic [IDX_W-1:0] w_idx;
  logic             addr_lo_unused;
  logic             is_cmd_d0;

  assign w_word         = wr_addr[ADDR_W-1:BOFF];
  assign w_tag          = w_word[SW-1:IDX_W];
  assign w_idx          = w_word[IDX_W-1:0];
  assign addr_lo_unused = ^wr_addr;
  assign is_cmd_d0      = (wr_data[7:0] == OP_CONFIRM);

  logic             mv_start, mv_run, mv_lag_v, mv_done;
  logic [IDX_W-1:0] mv_idx, mv_lag_idx;

  logic             host_store, capture_now;
  logic             buf_we, buf_re;
  logic [IDX_W-1:0] buf_waddr;
  logic [DW-1:0]    buf_wdata, buf_rdata;

  assign capture_now = (phase == PH_LOAD) && wr_en && !captured && (cnt != '0);
  assign host_store  = (phase == PH_LOAD) && wr_en && captured && !wr_protect && (w_tag == tag);
  assign mv_start    = capture_now ||
                       ((phase == PH_CONFIRM) && wr_en && is_cmd_d0 && !err);

  bwu_mover #(.N(WORDS), .IW(IDX_W)) i_mover (
    .clk(clk), .rst(rst), .start(mv_start), .run(mv_run), .idx(mv_idx),
    .lag_v(mv_lag_v), .lag_idx(mv_lag_idx), .done(mv_done)
  );

  always_comb begin
    buf_we    = host_store;
    buf_waddr = w_idx;
    buf_wdata = wr_data;
    if (phase == PH_FILL) begin
      buf_we    = mv_lag_v;
      buf_waddr = mv_lag_idx;
      buf_wdata = st_rdata;
    end else if (phase == PH_PEND) begin
      buf_we    = pend_ok;
      buf_waddr = pend_idx;
      buf_wdata = pend_data;
    end
  end

  assign buf_re = (phase == PH_FLUSH) && mv_run;

  bwu_ram #(.W(DW), .DEPTH(WORDS), .AW(IDX_W)) i_shadow (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .re(buf_re), .raddr(mv_idx), .rdata(buf_rdata)
  );

  assign st_re    = (phase == PH_FILL) && mv_run;
  assign st_we    = (phase == PH_FLUSH) && mv_lag_v;
  assign st_addr  = {tag, (phase == PH_FILL) ? mv_idx : mv_lag_idx};
  assign st_wdata = buf_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      captured  <= 1'b0;
      tag       <= '0;
      err       <= 1'b0;
      pend_idx  <= '0;
      pend_data <= '0;
      pend_ok   <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE:
          if (wr_en && wr_data[7:0] == OP_BUF_WRITE) phase <= PH_COUNT;
        PH_COUNT:
          if (wr_en) begin
            cnt   <= wr_data[CNT_W-1:0];
            phase <= PH_LOAD;
          end
        PH_LOAD:
          if (wr_en) begin
            if (capture_now) begin
              captured  <= 1'b1;
              tag       <= w_tag;
              pend_idx  <= w_idx;
              pend_data <= wr_data;
              pend_ok   <= !wr_protect;
              if (wr_protect) err <= 1'b1;
              cnt   <= cnt - 1'b1;
              phase <= PH_FILL;
            end else begin
              if (!host_store) err <= 1'b1;
              if (cnt == '0) phase <= PH_CONFIRM;
              else           cnt   <= cnt - 1'b1;
            end
          end
        PH_FILL:
          if (mv_done) phase <= PH_PEND;
        PH_PEND:
          phase <= PH_LOAD;
        PH_CONFIRM:
          if (wr_en) begin
            if (is_cmd_d0 && !err) phase <= PH_FLUSH;
            else begin
              captured <= 1'b0;
              phase    <= PH_IDLE;
            end
          end
        PH_FLUSH:
          if (mv_done) begin
            captured <= 1'b0;
            cnt      <= '0;
            phase    <= PH_IDLE;
          end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign sts_ready    = !((phase == PH_FILL) || (phase == PH_PEND) || (phase == PH_FLUSH));
  assign sts_prog_err = err;
  assign seq_idle     = (phase == PH_IDLE);

  AST_FILL_STARTS: assert property (@(posedge clk) disable iff (rst)
    capture_now |=> (!sts_ready && st_re)); // R4
  AST_LAST_WORD_CONFIRM: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOAD && wr_en && cnt == '0) |=> (phase == PH_CONFIRM)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    sts_prog_err |=> sts_prog_err); // R5
  AST_CLEAN_COMMIT: assert property (@(posedge clk) disable iff (rst)
    st_we |-> (!sts_prog_err && captured)); // R7
  AST_BAD_CONFIRM_DROPS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CONFIRM && wr_en && (!is_cmd_d0 || err)) |=> (seq_idle && !captured && !st_we)); // R8

endmodule

// File: tb/test_block_write_unit.sv
`timescale 1ns/1ps
module test_block_write_unit;

  localparam int BANK_BYTES = 2;
  localparam int DEV_BYTES  = 1;
  localparam int ADDR_W     = 13;
  localparam int DW         = 16;
  localparam int SW         = 12;
  localparam int NW         = 4096;
  localparam int BLKW       = 2048;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_protect = 1'b0;
  logic          st_re, st_we;
  logic [SW-1:0] st_addr;
  logic [DW-1:0] st_wdata;
  logic [DW-1:0] st_rdata;
  logic          sts_ready, sts_prog_err, seq_idle;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] mem     [NW];
  logic [DW-1:0] ref_mem [NW];

  always #2.5 clk = ~clk;

  block_write_unit #(.BANK_BYTES(BANK_BYTES), .DEV_BYTES(DEV_BYTES), .ADDR_W(ADDR_W)) i_block_write_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_protect(wr_protect), .st_re(st_re), .st_we(st_we), .st_addr(st_addr),
    .st_wdata(st_wdata), .st_rdata(st_rdata), .sts_ready(sts_ready),
    .sts_prog_err(sts_prog_err), .seq_idle(seq_idle)
  );

  always @(posedge clk) begin
    if (st_re) st_rdata <= mem[st_addr];
    if (st_we) mem[st_addr] <= st_wdata;
  end

  // data-phase vectors in the upper block: word offset and value, read back after commit
  localparam logic [10:0] VOFF [6] = '{11'd0, 11'd5, 11'd6, 11'd1000, 11'd2046, 11'd2047};
  localparam logic [15:0] VDAT [6] = '{16'hA001, 16'hB552, 16'h0C03, 16'h7E04, 16'h1235, 16'hFFE6};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input int word, input logic [15:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(word * 2);
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!sts_ready && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int i = 0; i < NW; i++) if (mem[i] !== ref_mem[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin
      mem[i]     = 16'((i * 7) ^ 16'h5A5A);
      ref_mem[i] = 16'((i * 7) ^ 16'h5A5A);
    end
    do_reset();
    // R1 reset state
    chk(sts_ready === 1'b1, "R1 ready", sts_ready, 1);
    chk(sts_prog_err === 1'b0, "R1 err", sts_prog_err, 0);
    chk(seq_idle === 1'b1, "R1 idle", seq_idle, 1);

    // R2 other opcode ignored, 0xE8 opens sequence
    do_write(0, 16'h0070);
    chk(seq_idle === 1'b1, "R2 other opcode", seq_idle, 1);
    do_write(0, 16'h00E8);
    chk(seq_idle === 1'b0 && sts_ready === 1'b1, "R2 open", {seq_idle, sts_ready}, 1);

    // R3 count 0x0105 masked to 5: six data words; R10 R9 window spans offsets 0..2047
    do_write(0, 16'h0105);
    for (int k = 0; k < 6; k++) begin
      do_write(BLKW + int'(VOFF[k]), VDAT[k]);
      if (k == 0) chk(sts_ready === 1'b0, "R4 busy during capture", sts_ready, 0);
      wait_ready();
      ref_mem[BLKW + int'(VOFF[k])] = VDAT[k];
    end
    chk(seq_idle === 1'b0 && sts_prog_err === 1'b0, "R3 awaiting confirm", {seq_idle, sts_prog_err}, 0);
    do_write(0, 16'h00D0);
    chk(sts_ready === 1'b0, "R7 busy during commit", sts_ready, 0);
    wait_ready();
    chk(seq_idle === 1'b1, "R7 back to idle", seq_idle, 1);
    cmp_mem("R7 R10 committed block");

    // R5 word in the other block rejected
    do_write(0, 16'h00E8);
    do_write(0, 16'h0001);
    do_write(BLKW + 3, 16'h1111);
    wait_ready();
    do_write(7, 16'h2222);
    chk(sts_prog_err === 1'b1, "R5 out of window", sts_prog_err, 1);
    do_write(0, 16'h00D0);
    chk(seq_idle === 1'b1 && sts_ready === 1'b1, "R8 confirm with error", {seq_idle, sts_ready}, 3);
    cmp_mem("R8 storage kept after error");
    do_reset();
    chk(sts_prog_err === 1'b0, "R1 error cleared", sts_prog_err, 0);

    // R6 count zero: no block captured
    do_write(0, 16'h00E8);
    do_write(0, 16'h0000);
    do_write(20, 16'h3333);
    chk(sts_prog_err === 1'b1 && sts_ready === 1'b1, "R6 no capture", {sts_prog_err, sts_ready}, 3);
    do_write(0, 16'h00D0);
    cmp_mem("R6 nothing stored");
    do_reset();

    // R6 protected storage
    wr_protect = 1'b1;
    do_write(0, 16'h00E8);
    do_write(0, 16'h0001);
    do_write(25, 16'h4444);
    wait_ready();
    do_write(26, 16'h5555);
    chk(sts_prog_err === 1'b1, "R6 protected", sts_prog_err, 1);
    do_write(0, 16'h00D0);
    cmp_mem("R6 protected storage kept");
    wr_protect = 1'b0;
    do_reset();

    // R8 wrong confirm byte discards
    do_write(0, 16'h00E8);
    do_write(0, 16'h0001);
    do_write(30, 16'h6666);
    wait_ready();
    do_write(31, 16'h7777);
    do_write(0, 16'h00FF);
    chk(seq_idle === 1'b1 && sts_prog_err === 1'b0, "R8 abort idle", {seq_idle, sts_prog_err}, 2);
    cmp_mem("R8 abort discards");

    // R1 reset drops a partly filled buffer
    do_write(0, 16'h00E8);
    do_write(0, 16'h0003);
    do_write(BLKW + 50, 16'hDEAD);
    wait_ready();
    do_reset();
    chk(seq_idle === 1'b1, "R1 reset mid sequence", seq_idle, 1);
    do_write(0, 16'h00E8);
    do_write(0, 16'h0001);
    do_write(40, 16'h0A0A);
    wait_ready();
    do_write(41, 16'h0B0B);
    do_write(0, 16'h00D0);
    wait_ready();
    ref_mem[40] = 16'h0A0A;
    ref_mem[41] = 16'h0B0B;
    cmp_mem("R1 R9 fresh commit only");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule